// File: doc/BRIEF.md
# Codec Control-Word Serial Writer

This block sends one 16-bit control word to an audio codec over a three-wire serial link: an active-low select, a serial clock and a data line. An extra output, the direction select, is held high for the whole of every transfer, so the codec always treats the transfer as a write. The word is formed from a 7-bit register number in the upper bits and a 9-bit value in the lower bits. It is shifted out most significant bit first.

A request is offered with `req_valid`, `req_addr` and `req_data`. It is taken on the rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a request offered during a transfer is neither taken nor queued. The source keeps `req_valid`, `req_addr` and `req_data` steady until the accepting edge.

All serial timing is counted in time steps. Each step lasts `STEP_CYCLES` system clocks; the default of 50 gives roughly 1 µs at 50 MHz. Within each bit the clock falls first, the data line changes one step later, and the clock rises one step after that. After the last bit, the select is released while the clock is low, and one further low-to-high clock edge follows.

Top module: `codec_cw_writer`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=1, `mosi`=0, `rw`=0, `req_ready`=1, `busy`=0 and `done`=0.
- R2: On the edge that accepts a request (`req_valid`=1 and `req_ready`=1), `cs_n` falls, `busy` rises and `req_ready` falls. `sclk` stays high.
- R3: The transmitted word is `{req_addr, req_data}`, with the address in bits 15..9 and the value in bits 8..0. It is sent MSB first, one bit per clock high phase, 16 bits in all.
- R4: Number the bits k = 0..15 from the MSB, and let the accepting edge be edge 0. `sclk` falls at edge (3k+1)·S, `mosi` takes bit k at edge (3k+2)·S, and `sclk` rises at edge (3k+3)·S. S is `STEP_CYCLES`.
- R5: At edge 49·S, `sclk` goes low and `cs_n` goes high together, and `mosi` returns to 0.
- R6: At edge 50·S, `sclk` goes high again while `cs_n` stays high.
- R7: At edge 51·S, `done` is high for exactly one cycle. On the same edge `busy` falls and `req_ready` rises.
- R8: A request offered while busy sees `req_ready`=0 and has no effect. The word in progress is sent unchanged, and no new transfer starts once the current one ends.
- R9: `rw` is high exactly while `busy` is high, which covers every cycle in which `cs_n` is low.
- R10: Every time step lasts exactly `STEP_CYCLES` system clocks, counted from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Codec register number |
| req_data | input | DATA_W | Register value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| cs_n | output | 1 | Codec select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the codec |
| rw | output | 1 | Direction select, high during a transfer |

## Verification
All results are measured from the accepting edge. The select, the serial clock and the data line change only at whole multiples of S edges after it. `done` is due at edge 51·S and clears one edge later. The bench keeps its own edge counter from the acceptance and samples every output at each falling clock edge. It compares each sample with the level the requirements give for that edge number, so a transition that arrives one system clock early or late is caught.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_DATA,
    ST_HIGH,
    ST_TAIL_LO,
    ST_TAIL_HI
  } cw_state_e;
endpackage

// File: rtl/cw_step_timer.sv
module cw_step_timer #(
  parameter int STEP_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

  // R10: a step boundary always restarts the count
  a_r10_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (cnt == '0));
endmodule

// File: rtl/cw_shifter.sv
module cw_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift,
  output logic             msb
);
  logic [WIDTH-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_word;
    else if (shift) sh <= {sh[WIDTH-2:0], 1'b0};
  end

  assign msb = sh[WIDTH-1];

  // R3: the first bit presented after a load is the word's MSB
  a_r3_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == $past(load_word[WIDTH-1])));
endmodule

// File: rtl/cw_sequencer.sv
module cw_sequencer
  import cw_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic tick,
  input  logic bit_in,
  output logic accept,
  output logic run,
  output logic shift,
  output logic req_ready,
  output logic busy,
  output logic done,
  output logic cs_n,
  output logic sclk,
  output logic mosi
);
  localparam int BIT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  cw_state_e        state;
  logic [BIT_W-1:0] bit_idx;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign run       = busy;
  assign accept    = req_valid && req_ready;
  assign shift     = tick && (state == ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n    <= 1'b0;
            bit_idx <= '0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            sclk  <= 1'b0;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            mosi  <= bit_in;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (bit_idx == LAST_BIT) begin
              cs_n  <= 1'b1;
              mosi  <= 1'b0;
              state <= ST_TAIL_LO;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              state   <= ST_LOW;
            end
          end
        end
        ST_TAIL_LO: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_TAIL_HI;
          end
        end
        ST_TAIL_HI: begin
          if (tick) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: acceptance selects the codec on the next cycle
  a_r2_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!cs_n && busy && sclk));
  // R5: select is released only while the serial clock is low
  a_r5_release_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !sclk);
  // R4: data is steady across each rising serial clock edge
  a_r4_data_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R7: completion pulse lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: completion coincides with return to idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && cs_n && sclk));
endmodule

// File: rtl/codec_cw_writer.sv
module codec_cw_writer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 9,
  parameter int STEP_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              rw
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic accept, run, tick, shift, bit_msb;

  cw_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (run),
    .tick    (tick)
  );

  cw_shifter #(.WIDTH(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word ({req_addr, req_data}),
    .shift     (shift),
    .msb       (bit_msb)
  );

  cw_sequencer #(.FRAME_W(FRAME_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .tick      (tick),
    .bit_in    (bit_msb),
    .accept    (accept),
    .run       (run),
    .shift     (shift),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi)
  );

  assign rw = busy;

  // R9: the codec is never selected without the write direction
  a_r9_rw_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> rw);
endmodule

// File: tb/tb_codec_cw_writer.sv
module tb_codec_cw_writer;
  localparam int S = 4;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'hFFFF, 16'h0000, 16'hAAAA,
                                       16'h5555, 16'h2E22, 16'h2300};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [6:0] req_addr = '0;
  logic [8:0] req_data = '0;
  logic req_ready, busy, done, cs_n, sclk, mosi, rw;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  codec_cw_writer #(.STEP_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rw(rw)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input bit poke);
    logic [15:0] rx = '0;
    int e_sclk = 0, e_mosi = 0, e_cs = 0, e_rw = 0, e_done = 0;
    int m;
    bit xs, xm, xc;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_addr = w[15:9];
    req_data = w[8:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!cs_n && busy && !req_ready && sclk, "R2 accept",
          {cs_n, busy, req_ready, sclk}, 4'b0101);
    for (int n = 0; n <= 51*S + 1; n++) begin
      m = n / S;
      if (m == 0) xs = 1'b1;
      else if (m <= 48) xs = (m % 3 == 0);
      else if (m == 49) xs = 1'b0;
      else xs = 1'b1;
      if (m >= 2 && m <= 48) xm = w[15 - (m - 2) / 3];
      else xm = 1'b0;
      xc = (m >= 49);
      if (n < 51*S) begin
        if (sclk !== xs) e_sclk++;
        if (mosi !== xm) e_mosi++;
        if (cs_n !== xc) e_cs++;
        if (rw !== 1'b1 || busy !== 1'b1) e_rw++;
        if (done !== 1'b0) e_done++;
        if (m >= 3 && m <= 48 && (m % 3 == 0) && (n % S == 0)) rx = {rx[14:0], mosi};
      end
      if (n == 50*S) check(sclk && cs_n, "R6 trailing clock edge", {sclk, cs_n}, 2'b11);
      if (n == 51*S)
        check(done && req_ready && !busy && !rw, "R7 done pulse",
              {done, req_ready, busy, rw}, 4'b1100);
      if (n == 51*S + 1) check(!done, "R7 done single cycle", done, 0);
      if (poke && n == 5) begin
        check(!req_ready, "R8 ready low while busy", req_ready, 0);
        req_valid = 1'b1;
        req_addr = ~w[15:9];
        req_data = ~w[8:0];
      end
      if (poke && n == 7) req_valid = 1'b0;
      @(negedge clk);
    end
    check(rx == w, poke ? "R8 word unchanged by busy request" : "R3 word", rx, w);
    check(e_sclk == 0 && e_mosi == 0, "R4 R10 bit timing", e_sclk + e_mosi, 0);
    check(e_cs == 0, "R5 select window", e_cs, 0);
    check(e_rw == 0, "R9 rw while busy", e_rw, 0);
    check(e_done == 0, "R7 no early done", e_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !mosi && !rw && req_ready && !busy && !done, "R1 reset state",
          {cs_n, sclk, mosi, rw, req_ready, busy, done}, 7'b1100100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && sclk && req_ready, "R1 idle after reset", {cs_n, sclk, req_ready}, 3'b111);
    for (int i = 0; i < NV; i++) run_frame(VEC[i], i == 2);
    // R8: the request offered while busy must not start a frame afterwards
    bad = 0;
    for (int n = 0; n < 3*S; n++) begin
      if (!cs_n || busy) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 no deferred start", bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule